// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the start and running address and count registers of a small set of DMA channels. A processor programs and inspects the registers through an 8-bit register port, one byte per access. One byte-pointer flip-flop is shared by every register. It decides whether an access touches the low or the high byte, and it flips after each access. Writing the high byte of either register of a channel restarts that channel. The running address is loaded from the start address, and the progress count goes back to zero.

Progress comes from the transfer engine through an update input. Each update carries a channel number and a new progress count. A readback of the address register shows the start address moved on by the progress count, moving down when the channel's decrement flag is set. A readback of the count register shows the programmed count minus the progress count. A parameter selects word-wide operation. In that mode the port offset is divided by two and every address and count value carries one extra low bit. The controller register block drives the flip-flop clear input and the per-channel decrement flags.

The update input is a valid-only stream. It is always accepted and applies no back-pressure, so each cycle with `upd_valid` high is one update. Read data comes back one cycle after the read strobe, qualified by `rd_valid`.

Top module: `dma_chan_regs`

## Requirements
- R1: The register index is `reg_addr >> S`, where S is 1 in word mode and 0 otherwise. Index bits 3:1 select the channel. Index bit 0 selects the address register (0) or the count register (1).
- R2: Every access toggles the single byte-pointer flip-flop that all channels share. An access is a cycle with `reg_wr` or `reg_rd` high, and it toggles the flip-flop once.
- R3: A write with the flip-flop at 0 replaces bits 7:0 of the selected start register. A write with the flip-flop at 1 replaces bits 15:8. The other byte is unchanged.
- R4: A high-byte write to either register of a channel reloads that channel. The running address becomes the new start address shifted left by S, and the progress count becomes 0. A low-byte write does not reload.
- R5: The address readback value is the running address plus the progress count. When the channel's `chan_dec` bit is set, it is the running address minus the progress count. The result wraps at 16+S bits.
- R6: The count readback value is the start count shifted left by S, minus the progress count. The result wraps at 16+S bits.
- R7: A read returns bits [S + 8*f +: 8] of the readback value, where f is the flip-flop value before the access.
- R8: `cur_addr` shows each channel's address readback value. `remain` shows ((start count + 1) << S) minus the progress count.
- R9: `ff_clear` forces the flip-flop to 0. It takes priority over a toggle in the same cycle.
- R10: An update loads `upd_count` into the progress count of channel `upd_chan`. A reload of the same channel in the same cycle wins, and the progress count becomes 0.
- R11: An access to a channel number of NCHAN or more still toggles the flip-flop. A write to such a channel changes no register, and a read of it returns 0.
- R12: `rd_valid` pulses in the cycle after a read, with `rd_data` valid. If `reg_wr` and `reg_rd` are both high, the write alone takes place and `rd_valid` stays low.
- R13: After reset all registers and the flip-flop are 0, `cur_addr` is 0, and `remain` is 1 << S for every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4+S | Register port offset |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe |
| reg_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8 | Read byte |
| ff_clear | input | 1 | Clear the byte-pointer flip-flop |
| chan_dec | input | NCHAN | Per-channel decrement flag |
| upd_valid | input | 1 | Progress update valid (always accepted) |
| upd_chan | input | clog2(NCHAN) | Channel of the update |
| upd_count | input | 16+S | New progress count |
| cur_addr | output | NCHAN*(16+S) | Current address per channel, channel 0 in the low bits |
| remain | output | NCHAN*(17+S) | Remaining transfer length per channel |

## Verification
A flip-flop that fails to toggle, or toggles twice, shows on the very next read. The read returns the other byte of the value, so an out-of-phase pointer is caught within one access. A missed or spurious reload shows at once on `cur_addr` and `remain`, and on the next address readback. A wrong shift or the wrong sign for a decrementing channel changes the readback bytes and `cur_addr` in the cycle after the update that exposes it. A read strobe swallowed by a write shows as a missing or extra `rd_valid` one cycle later.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dmar_byteptr.sv
module dmar_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic clear,
  output logic ff
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ff <= 1'b0;
    else if (clear)  ff <= 1'b0;
    else if (access) ff <= ~ff;
  end

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !clear) |=> (ff != $past(ff)));
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ff);
endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
  import dmar_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int VAL_W = 16 + SHIFT,
  parameter int LEN_W = VAL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic             wr_hi,
  input  logic [7:0]       wr_data,
  input  logic             upd_en,
  input  logic [VAL_W-1:0] upd_cnt,
  input  logic             dec,
  output logic [VAL_W-1:0] addr_val,
  output logic [VAL_W-1:0] cnt_val,
  output logic [LEN_W-1:0] remain
);
  logic [15:0]      base_addr, base_cnt, nxt_base_addr, nxt_base_cnt;
  logic [VAL_W-1:0] run_addr, progress;
  logic [LEN_W-1:0] total;
  logic             reload;

  assign reload = wr_en && wr_hi;

  always_comb begin
    nxt_base_addr = base_addr;
    nxt_base_cnt  = base_cnt;
    if (wr_en) begin
      if (wr_sel == SEL_ADDR) begin
        if (wr_hi) nxt_base_addr[15:8] = wr_data;
        else       nxt_base_addr[7:0]  = wr_data;
      end else begin
        if (wr_hi) nxt_base_cnt[15:8] = wr_data;
        else       nxt_base_cnt[7:0]  = wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      run_addr  <= '0;
      progress  <= '0;
    end else begin
      base_addr <= nxt_base_addr;
      base_cnt  <= nxt_base_cnt;
      if (reload) begin
        run_addr <= VAL_W'(nxt_base_addr) << SHIFT;
        progress <= '0;
      end else if (upd_en) begin
        progress <= upd_cnt;
      end
    end
  end

  assign addr_val = dec ? (run_addr - progress) : (run_addr + progress);
  assign cnt_val  = (VAL_W'(base_cnt) << SHIFT) - progress;
  assign total    = (LEN_W'(base_cnt) + LEN_W'(1)) << SHIFT;
  assign remain   = total - LEN_W'(progress);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (progress == '0) && (run_addr == (VAL_W'(base_addr) << SHIFT)));
  assert_low_no_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> $stable(run_addr));
  assert_hi_byte_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi && wr_sel == SEL_ADDR) |=>
      (base_addr[7:0] == $past(base_addr[7:0])) && (base_addr[15:8] == $past(wr_data)));
  assert_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !reload) |=> (progress == $past(upd_cnt)));
endmodule

// File: rtl/dmar_rdsel.sv
module dmar_rdsel
  import dmar_pkg::*;
#(
  parameter int NCHAN = 4,
  parameter int SHIFT = 0,
  parameter int VAL_W = 16 + SHIFT
) (
  input  logic [2:0]                  chan,
  input  reg_sel_e                    sel,
  input  logic                        ff,
  input  logic [NCHAN-1:0][VAL_W-1:0] addr_vals,
  input  logic [NCHAN-1:0][VAL_W-1:0] cnt_vals,
  output logic [7:0]                  rbyte
);
  logic [VAL_W-1:0] val, shifted;

  always_comb begin
    val = '0;
    for (int i = 0; i < NCHAN; i++) begin
      if (chan == 3'(i)) val = (sel == SEL_COUNT) ? cnt_vals[i] : addr_vals[i];
    end
    shifted = val >> (SHIFT + (ff ? 8 : 0));
    rbyte   = shifted[7:0];
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmar_pkg::*;
#(
  parameter int NCHAN = 4,
  parameter int WIDE  = 0,
  localparam int SHIFT = (WIDE != 0) ? 1 : 0,
  localparam int OFS_W = 4 + SHIFT,
  localparam int VAL_W = 16 + SHIFT,
  localparam int LEN_W = VAL_W + 1,
  localparam int CH_W  = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [OFS_W-1:0]       reg_addr,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [7:0]             reg_wdata,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  input  logic                   ff_clear,
  input  logic [NCHAN-1:0]       chan_dec,
  input  logic                   upd_valid,
  input  logic [CH_W-1:0]        upd_chan,
  input  logic [VAL_W-1:0]       upd_count,
  output logic [NCHAN*VAL_W-1:0] cur_addr,
  output logic [NCHAN*LEN_W-1:0] remain
);
  logic [3:0]                  idx;
  logic [2:0]                  chan;
  reg_sel_e                    sel;
  logic                        ff, rd_act;
  logic [7:0]                  rbyte;
  logic [NCHAN-1:0][VAL_W-1:0] addr_vals, cnt_vals;

  assign idx    = reg_addr[SHIFT +: 4];
  assign chan   = idx[3:1];
  assign sel    = reg_sel_e'(idx[0]);
  assign rd_act = reg_rd && !reg_wr;

  dmar_byteptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .access (reg_wr || reg_rd),
    .clear  (ff_clear),
    .ff     (ff)
  );

  for (genvar i = 0; i < NCHAN; i++) begin : g_chan
    logic [LEN_W-1:0] rem_i;
    dmar_chan #(.SHIFT(SHIFT), .VAL_W(VAL_W), .LEN_W(LEN_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr && (chan == 3'(i))),
      .wr_sel   (sel),
      .wr_hi    (ff),
      .wr_data  (reg_wdata),
      .upd_en   (upd_valid && (upd_chan == CH_W'(i))),
      .upd_cnt  (upd_count),
      .dec      (chan_dec[i]),
      .addr_val (addr_vals[i]),
      .cnt_val  (cnt_vals[i]),
      .remain   (rem_i)
    );
    assign cur_addr[i*VAL_W +: VAL_W] = addr_vals[i];
    assign remain[i*LEN_W +: LEN_W]   = rem_i;
  end

  dmar_rdsel #(.NCHAN(NCHAN), .SHIFT(SHIFT), .VAL_W(VAL_W)) u_rdsel (
    .chan      (chan),
    .sel       (sel),
    .ff        (ff),
    .addr_vals (addr_vals),
    .cnt_vals  (cnt_vals),
    .rbyte     (rbyte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_act;
      if (rd_act) rd_data <= rbyte;
    end
  end

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> rd_valid);
  assert_no_rd_on_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> !rd_valid);
  assert_oor_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (chan >= 3'(NCHAN)) && !upd_valid) |=> ($stable(cur_addr) && $stable(remain)));
endmodule

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
  localparam int OP_WR = 0, OP_RD = 1, OP_UPD = 2, OP_CLR = 3, OP_DEC = 4;
  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;
  localparam int NV = 36;
  // Byte mode: index 2 = ch1 address, 3 = ch1 count, 4 = ch2 address, 10 = ch5 (absent)
  localparam vec_t TBL [NV] = '{
    '{3'(OP_CLR), 4'd0, 16'h0000, 8'h00, 8'd9},
    '{3'(OP_WR),  4'd2, 16'h0034, 8'h00, 8'd3},
    '{3'(OP_WR),  4'd2, 16'h0012, 8'h00, 8'd3},
    '{3'(OP_WR),  4'd3, 16'h000F, 8'h00, 8'd3},
    '{3'(OP_WR),  4'd3, 16'h0000, 8'h00, 8'd3},
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h34, 8'd7},   // R7 low byte
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h12, 8'd7},   // R7 high byte
    '{3'(OP_UPD), 4'd1, 16'h0005, 8'h00, 8'd10},
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h39, 8'd5},   // R5 add progress
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h12, 8'd5},
    '{3'(OP_RD),  4'd3, 16'h0000, 8'h0A, 8'd6},   // R6 count minus progress
    '{3'(OP_RD),  4'd3, 16'h0000, 8'h00, 8'd6},
    '{3'(OP_DEC), 4'd0, 16'h0002, 8'h00, 8'd5},
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h2F, 8'd5},   // R5 decrement
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h12, 8'd5},
    '{3'(OP_WR),  4'd4, 16'h00AA, 8'h00, 8'd2},   // R2 other channel moves shared pointer
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h12, 8'd2},
    '{3'(OP_WR),  4'd2, 16'h0077, 8'h00, 8'd4},   // low byte, no reload
    '{3'(OP_CLR), 4'd0, 16'h0000, 8'h00, 8'd9},   // R9 clear mid pair
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h2F, 8'd4},   // R4 running address kept
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h12, 8'd4},
    '{3'(OP_WR),  4'd10, 16'h0055, 8'h00, 8'd11}, // R11 absent channel toggles
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h12, 8'd11},
    '{3'(OP_RD),  4'd10, 16'h0000, 8'h00, 8'd11}, // R11 reads 0
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h12, 8'd11},
    '{3'(OP_UPD), 4'd1, 16'h0003, 8'h00, 8'd10},
    '{3'(OP_WR),  4'd2, 16'h0000, 8'h00, 8'd3},
    '{3'(OP_WR),  4'd2, 16'h0056, 8'h00, 8'd4},   // reload clears progress
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h00, 8'd4},
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h56, 8'd4},
    '{3'(OP_UPD), 4'd1, 16'h0001, 8'h00, 8'd10},
    '{3'(OP_RD),  4'd2, 16'h0000, 8'hFF, 8'd5},   // R5 borrow across bytes
    '{3'(OP_RD),  4'd2, 16'h0000, 8'h55, 8'd5},
    '{3'(OP_RD),  4'd3, 16'h0000, 8'h0E, 8'd6},
    '{3'(OP_RD),  4'd3, 16'h0000, 8'h00, 8'd6},
    '{3'(OP_DEC), 4'd0, 16'h0000, 8'h00, 8'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0, ff_clear = 0, upd_valid = 0, rd_valid;
  logic [7:0] reg_wdata = '0, rd_data;
  logic [3:0] chan_dec = '0;
  logic [1:0] upd_chan = '0;
  logic [15:0] upd_count = '0;
  logic [63:0] cur_addr;
  logic [67:0] remain;

  dma_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .ff_clear(ff_clear),
    .chan_dec(chan_dec), .upd_valid(upd_valid), .upd_chan(upd_chan), .upd_count(upd_count),
    .cur_addr(cur_addr), .remain(remain)
  );

  logic [4:0] w_addr = '0;
  logic w_wr = 0, w_rd = 0, w_rdv;
  logic [7:0] w_wdata = '0, w_rdata;
  logic w_upd = 0;
  logic [16:0] w_cnt = '0;
  logic [67:0] w_cur;
  logic [71:0] w_rem;

  dma_chan_regs #(.WIDE(1)) dut_w (
    .clk(clk), .rst_n(rst_n), .reg_addr(w_addr), .reg_wr(w_wr), .reg_rd(w_rd),
    .reg_wdata(w_wdata), .rd_valid(w_rdv), .rd_data(w_rdata), .ff_clear(1'b0),
    .chan_dec(4'b0000), .upd_valid(w_upd), .upd_chan(2'd0), .upd_count(w_cnt),
    .cur_addr(w_cur), .remain(w_rem)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] b);
    reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
    chk("R12 rd_valid", 32'(rd_valid), 32'd1);
    b = rd_data;
  endtask

  task automatic w_write(input logic [4:0] a, input logic [7:0] d);
    w_addr = a; w_wdata = d; w_wr = 1;
    @(negedge clk); w_wr = 0;
  endtask

  task automatic w_read(input logic [4:0] a, output logic [7:0] b);
    w_addr = a; w_rd = 1;
    @(negedge clk); w_rd = 0;
    b = w_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    chk("R13 cur_addr", 32'(cur_addr[31:0]), 32'd0);
    chk("R13 remain ch0", 32'(remain[16:0]), 32'd1);
    chk("R13 remain ch3", 32'(remain[67:51]), 32'd1);
    chk("R13 rd_valid", 32'(rd_valid), 32'd0);
    chk("R13 wide remain", 32'(w_rem[17:0]), 32'd2);
    do_rd(4'd0, b); chk("R13 read zero", 32'(b), 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (int'(TBL[i].op))
        OP_WR: do_wr(TBL[i].addr, TBL[i].data[7:0]);
        OP_RD: begin
          do_rd(TBL[i].addr, b);
          chk($sformatf("R%0d vec %0d", TBL[i].req, i), 32'(b), 32'(TBL[i].exp));
        end
        OP_UPD: begin
          upd_chan = TBL[i].addr[1:0]; upd_count = TBL[i].data; upd_valid = 1;
          @(negedge clk); upd_valid = 0;
        end
        OP_CLR: begin ff_clear = 1; @(negedge clk); ff_clear = 0; end
        default: begin chan_dec = TBL[i].data[3:0]; @(negedge clk); end
      endcase
    end

    // R8 port outputs: ch1 start 0x5600, progress 1, count 0x000F
    chk("R8 cur_addr ch1", 32'(cur_addr[31:16]), 32'h5601);
    chk("R8 remain ch1", 32'(remain[33:17]), 32'd15);

    // R10 reload and update in the same cycle: reload wins
    do_wr(4'd2, 8'h00);
    reg_addr = 4'd2; reg_wdata = 8'h60; reg_wr = 1;
    upd_chan = 2'd1; upd_count = 16'd9; upd_valid = 1;
    @(negedge clk); reg_wr = 0; upd_valid = 0;
    chk("R10 reload beats update", 32'(cur_addr[31:16]), 32'h6000);
    upd_count = 16'd9; upd_valid = 1; @(negedge clk); upd_valid = 0;
    chk("R10 update alone", 32'(cur_addr[31:16]), 32'h6009);

    // R9 clear in the same cycle as a read toggle
    do_rd(4'd2, b); chk("R9 low before", 32'(b), 32'h09);
    reg_addr = 4'd2; reg_rd = 1; ff_clear = 1;
    @(negedge clk); reg_rd = 0; ff_clear = 0;
    chk("R9 read uses old pointer", 32'(rd_data), 32'h60);
    do_rd(4'd2, b); chk("R9 pointer forced low", 32'(b), 32'h09);

    // R12 write and read together: write only, no rd_valid
    reg_addr = 4'd2; reg_wdata = 8'h70; reg_wr = 1; reg_rd = 1;
    @(negedge clk); reg_wr = 0; reg_rd = 0;
    chk("R12 no rd_valid on write", 32'(rd_valid), 32'd0);
    chk("R12 write took place", 32'(cur_addr[31:16]), 32'h7000);

    // R1 / R7 word mode: offsets halved, values shifted by one
    w_write(5'd0, 8'h10); w_write(5'd0, 8'h20);
    w_write(5'd2, 8'h03); w_write(5'd2, 8'h00);
    chk("R1 wide cur_addr", 32'(w_cur[16:0]), 32'h4020);
    chk("R8 wide remain", 32'(w_rem[17:0]), 32'd8);
    w_cnt = 17'd2; w_upd = 1; @(negedge clk); w_upd = 0;
    w_read(5'd0, b); chk("R7 wide low byte", 32'(b), 32'h11);
    w_read(5'd0, b); chk("R7 wide high byte", 32'(b), 32'h20);
    w_read(5'd2, b); chk("R6 wide count", 32'(b), 32'h02);
    chk("R8 wide remain after update", 32'(w_rem[17:0]), 32'd6);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule